// File: doc/BRIEF.md
# Keyed System Control Register Block

This block is the system control word bank that sits beside a processor core. Software reaches it through a plain 32-bit register port: a write strobe, a 12-bit byte offset and write data. Read data is driven combinationally from the offset. Four words are decoded:

- a pend control word at 0xD04;
- a vector table base at 0xD08;
- a key-protected reset control word at 0xD0C;
- a low-power configuration word at 0xD10.

The pend control word holds no state of its own. Writing 1 to its set or clear bits produces one-cycle strobes toward the exception logic, for NMI, PendSV and the tick exception. A set bit takes precedence over the clear bit of the same exception. Reading the word shows the pending status that the exception logic feeds back in.

Writes to the reset control word are filtered by a 16-bit key in the upper half of the data. An accepted write can latch a system reset request, which stays raised until the block itself is reset. It can also fire a clear-active strobe, but only while the core reports that it is halted. The vector base and the sleep controls are plain stored fields that drive outputs.

Top module: `sys_ctrl_regs`

## Requirements
- R1: A write to 0xD04 with bit 31, 28 or 26 set raises `pend_set_o[2]`, `pend_set_o[1]` or `pend_set_o[0]` (NMI, PendSV, tick) for exactly the one cycle after the write edge.
- R2: A write to 0xD04 with bit 30, 27 or 25 set raises `pend_clr_o[2]`, `[1]` or `[0]` for one cycle, but only if that exception's set bit (31, 28, 26) is 0 in the same write. Zero bits in the written data produce no strobe.
- R3: A read of 0xD04 returns `pend_stat_i[2]` in bit 31, `pend_stat_i[1]` in bit 28 and `pend_stat_i[0]` in bit 26. All other bits read 0.
- R4: A write to 0xD08 stores bits 31:8. These drive `vtab_base_o[31:8]` and read back in place; bits 7:0 of both are 0. The value changes only on a write to 0xD08.
- R5: A write to 0xD0C with bits 31:16 equal to 0x05FA and bit 2 set raises `rst_req_o` from the next cycle on. It stays high until `rst_ni` is asserted. Without the key the write has no effect at all.
- R6: A keyed write to 0xD0C with bit 1 set pulses `clr_active_o` for one cycle, only if `core_halted_i` is high at the write edge.
- R7: A read of 0xD0C always returns 0xFA050000: key field 0xFA05, bit 15 (endianness) 0 for little-endian, and the request bits 2 and 1 as 0.
- R8: A write to 0xD10 stores bit 1 (sleep on exit), bit 2 (deep sleep) and bit 4 (event on pend). These drive `sleep_on_exit_o`, `sleep_deep_o` and `sev_on_pend_o` and read back in place; other bits read 0.
- R9: While `rst_ni` is low, every output is 0 and every stored field reads 0.
- R10: Offsets other than the four decoded words read 0. Writes to them change no output and no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pend_stat_i | input | 3 | Pending status: [2] NMI, [1] PendSV, [0] tick |
| core_halted_i | input | 1 | Core is in debug halt |
| pend_set_o | output | 3 | One-cycle set-pending strobes, same bit order |
| pend_clr_o | output | 3 | One-cycle clear-pending strobes, same bit order |
| rst_req_o | output | 1 | Latched system reset request |
| clr_active_o | output | 1 | One-cycle clear-all-active strobe |
| vtab_base_o | output | 32 | Vector table base address |
| sleep_on_exit_o | output | 1 | Sleep on return to thread level |
| sleep_deep_o | output | 1 | Deep sleep selected instead of sleep |
| sev_on_pend_o | output | 1 | Pending events wake the core |

## Verification
The pend word is hit with single-bit patterns, with set-plus-clear pairs that must resolve to set only, and with random full words. Together these separate correct precedence from plain bit mapping. The reset control word gets random data with and without the exact key, and with the halt input toggled. This tells key filtering apart from halt gating. The reset request is shown to persist across later unkeyed writes and to drop only on reset. Writes to an unmapped offset with all data bits high show that the decode does not leak into any stored field.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_EXC = 3;  // 0 tick, 1 pendsv, 2 nmi
  localparam int unsigned VTAB_LSB = 8;
  localparam int unsigned KEY_W   = 16;

  localparam logic [ADDR_W-1:0] OFS_PEND = 12'hD04;
  localparam logic [ADDR_W-1:0] OFS_VTAB = 12'hD08;
  localparam logic [ADDR_W-1:0] OFS_RSTC = 12'hD0C;
  localparam logic [ADDR_W-1:0] OFS_SLP  = 12'hD10;

  localparam logic [KEY_W-1:0] WR_KEY = 16'h05FA;
  localparam logic [KEY_W-1:0] RD_KEY = 16'hFA05;

  localparam int SET_POS [NUM_EXC] = '{26, 28, 31};
  localparam int CLR_POS [NUM_EXC] = '{25, 27, 30};

  localparam int RST_REQ_BIT = 2;
  localparam int CLR_ACT_BIT = 1;
  localparam int SOE_BIT     = 1;
  localparam int SDP_BIT     = 2;
  localparam int SEV_BIT     = 4;

  typedef struct packed {
    logic pend;
    logic vtab;
    logic rstc;
    logic slp;
  } sel_t;
endpackage

// File: rtl/sys_ctrl_decode.sv
module sys_ctrl_decode
  import sys_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o
);
  always_comb begin
    sel_o      = '0;
    sel_o.pend = (addr_i == OFS_PEND);
    sel_o.vtab = (addr_i == OFS_VTAB);
    sel_o.rstc = (addr_i == OFS_RSTC);
    sel_o.slp  = (addr_i == OFS_SLP);
  end
endmodule

// File: rtl/sys_ctrl_pend.sv
module sys_ctrl_pend
  import sys_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_EXC-1:0] set_o,
  output logic [NUM_EXC-1:0] clr_o
);
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_exc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_o[i] <= 1'b0;
        clr_o[i] <= 1'b0;
      end else begin
        set_o[i] <= wr_en_i && wdata_i[SET_POS[i]];
        // set wins over clear in the same write
        clr_o[i] <= wr_en_i && wdata_i[CLR_POS[i]] && !wdata_i[SET_POS[i]];
      end
    end
  end
endmodule

// File: rtl/sys_ctrl_cfg.sv
module sys_ctrl_cfg
  import sys_ctrl_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  sel_t                       sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       core_halted_i,
  output logic [DATA_W-VTAB_LSB-1:0] vtab_q_o,
  output logic                       rst_req_o,
  output logic                       clr_active_o,
  output logic                       soe_o,
  output logic                       sdp_o,
  output logic                       sev_o
);
  logic keyed;
  assign keyed = wr_i && sel_i.rstc && (wdata_i[DATA_W-1 -: KEY_W] == WR_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vtab_q_o     <= '0;
      rst_req_o    <= 1'b0;
      clr_active_o <= 1'b0;
      soe_o        <= 1'b0;
      sdp_o        <= 1'b0;
      sev_o        <= 1'b0;
    end else begin
      if (wr_i && sel_i.vtab) vtab_q_o <= wdata_i[DATA_W-1:VTAB_LSB];
      if (wr_i && sel_i.slp) begin
        soe_o <= wdata_i[SOE_BIT];
        sdp_o <= wdata_i[SDP_BIT];
        sev_o <= wdata_i[SEV_BIT];
      end
      // request held until the reset it triggers comes back
      if (keyed && wdata_i[RST_REQ_BIT]) rst_req_o <= 1'b1;
      clr_active_o <= keyed && wdata_i[CLR_ACT_BIT] && core_halted_i;
    end
  end
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [11:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [2:0]         pend_stat_i,
  input  logic               core_halted_i,
  output logic [2:0]         pend_set_o,
  output logic [2:0]         pend_clr_o,
  output logic               rst_req_o,
  output logic               clr_active_o,
  output logic [31:0]        vtab_base_o,
  output logic               sleep_on_exit_o,
  output logic               sleep_deep_o,
  output logic               sev_on_pend_o
);
  sel_t sel;
  logic [DATA_W-VTAB_LSB-1:0] vtab_q;
  logic [DATA_W-1:0] pend_rd;

  sys_ctrl_decode u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  sys_ctrl_pend u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_i && sel.pend),
    .wdata_i (wdata_i),
    .set_o   (pend_set_o),
    .clr_o   (pend_clr_o)
  );

  sys_ctrl_cfg u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .sel_i         (sel),
    .wdata_i       (wdata_i),
    .core_halted_i (core_halted_i),
    .vtab_q_o      (vtab_q),
    .rst_req_o     (rst_req_o),
    .clr_active_o  (clr_active_o),
    .soe_o         (sleep_on_exit_o),
    .sdp_o         (sleep_deep_o),
    .sev_o         (sev_on_pend_o)
  );

  assign vtab_base_o = {vtab_q, {VTAB_LSB{1'b0}}};

  always_comb begin
    pend_rd = '0;
    for (int i = 0; i < NUM_EXC; i++) pend_rd[SET_POS[i]] = pend_stat_i[i];
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel.pend: rdata_o = pend_rd;
      sel.vtab: rdata_o = vtab_base_o;
      sel.rstc: rdata_o = {RD_KEY, {(DATA_W-KEY_W){1'b0}}};
      sel.slp: begin
        rdata_o[SOE_BIT] = sleep_on_exit_o;
        rdata_o[SDP_BIT] = sleep_deep_o;
        rdata_o[SEV_BIT] = sev_on_pend_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sys_ctrl_regs_chk.sv
module sys_ctrl_regs_chk
  import sys_ctrl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic [11:0] addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [2:0]  pend_set_o,
  input logic [2:0]  pend_clr_o,
  input logic        core_halted_i,
  input logic        rst_req_o,
  input logic        clr_active_o,
  input logic [31:0] vtab_base_o
);
  assert_nmi_set_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_set_o[2] |-> $past(wr_i && addr_i == OFS_PEND && wdata_i[31]));

  assert_set_beats_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_set_o & pend_clr_o) == 3'b000);

  assert_vtab_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFS_VTAB) |=> $stable(vtab_base_o));

  assert_rst_req_keyed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(wr_i && addr_i == OFS_RSTC &&
                               wdata_i[31:16] == WR_KEY && wdata_i[2]));

  assert_rst_req_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  assert_clr_act_halted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_active_o |-> $past(core_halted_i && wr_i && addr_i == OFS_RSTC));

  assert_rstc_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFS_RSTC |-> rdata_o == 32'hFA05_0000);
endmodule

bind sys_ctrl_regs sys_ctrl_regs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_i          (wr_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .pend_set_o    (pend_set_o),
  .pend_clr_o    (pend_clr_o),
  .core_halted_i (core_halted_i),
  .rst_req_o     (rst_req_o),
  .clr_active_o  (clr_active_o),
  .vtab_base_o   (vtab_base_o)
);

// File: tb/sys_ctrl_regs_test.sv
module sys_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  pend_stat_i = '0;
  logic        core_halted_i = 1'b0;
  logic [2:0]  pend_set_o, pend_clr_o;
  logic        rst_req_o, clr_active_o;
  logic [31:0] vtab_base_o;
  logic        sleep_on_exit_o, sleep_deep_o, sev_on_pend_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  sys_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_stat_i(pend_stat_i),
    .core_halted_i(core_halted_i), .pend_set_o(pend_set_o),
    .pend_clr_o(pend_clr_o), .rst_req_o(rst_req_o),
    .clr_active_o(clr_active_o), .vtab_base_o(vtab_base_o),
    .sleep_on_exit_o(sleep_on_exit_o), .sleep_deep_o(sleep_deep_o),
    .sev_on_pend_o(sev_on_pend_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; addr_i = 12'h000; wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
    addr_i = 12'h000;
  endtask

  // {set[2:0], clr[2:0]}
  function automatic logic [5:0] pend_exp(input logic [31:0] d);
    logic [2:0] s, c;
    s = {d[31], d[28], d[26]};
    c = {d[30], d[27], d[25]} & ~s;
    return {s, c};
  endfunction

  function automatic logic [31:0] pend_rd_exp(input logic [2:0] p);
    logic [31:0] r;
    r = '0;
    r[31] = p[2]; r[28] = p[1]; r[26] = p[0];
    return r;
  endfunction

  function automatic logic [31:0] outs();
    return {pend_set_o, pend_clr_o, rst_req_o, clr_active_o, sleep_on_exit_o,
            sleep_deep_o, sev_on_pend_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r, d, v;
    logic [2:0]  sl;
    void'($urandom(32'd20240611));

    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", outs(), '0);
    chk("R9 vtab in reset", vtab_base_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(12'hD10, r); chk("R9 sleep word after reset", r, '0);
    rd(12'hD08, r); chk("R9 vtab word after reset", r, '0);

    // R1 directed set strobes, one cycle only
    wr(12'hD04, 32'h8000_0000);
    chk("R1 nmi set", {pend_set_o, pend_clr_o}, 6'b100_000);
    @(negedge clk);
    chk("R1 strobe one cycle", {pend_set_o, pend_clr_o}, 6'b000_000);
    wr(12'hD04, 32'h1400_0000);
    chk("R1 pendsv+tick set", {pend_set_o, pend_clr_o}, 6'b011_000);
    // R2 clear and precedence
    wr(12'hD04, 32'h4000_0000);
    chk("R2 nmi clr", {pend_set_o, pend_clr_o}, 6'b000_100);
    wr(12'hD04, 32'hDE00_0000);
    chk("R2 set beats clr", {pend_set_o, pend_clr_o}, 6'b111_000);
    wr(12'hD04, 32'h0A00_0000);
    chk("R2 pendsv+tick clr", {pend_set_o, pend_clr_o}, 6'b000_011);
    wr(12'hD04, 32'h0000_0000);
    chk("R2 zero write no strobe", {pend_set_o, pend_clr_o}, 6'b000_000);

    // R1 R2 random pend writes
    for (int i = 0; i < 150; i++) begin
      d = $urandom();
      wr(12'hD04, d);
      chk("R1/R2 random pend", {pend_set_o, pend_clr_o}, pend_exp(d));
    end

    // R3 pend readback
    for (int i = 0; i < 8; i++) begin
      pend_stat_i = 3'(i);
      rd(12'hD04, r);
      chk("R3 pend readback", r, pend_rd_exp(3'(i)));
    end
    pend_stat_i = '0;

    // R4 vector base
    for (int i = 0; i < 20; i++) begin
      d = $urandom();
      wr(12'hD08, d);
      chk("R4 vtab out", vtab_base_o, {d[31:8], 8'h00});
      rd(12'hD08, r);
      chk("R4 vtab readback", r, {d[31:8], 8'h00});
    end
    v = vtab_base_o;

    // R8 sleep word
    for (int i = 0; i < 20; i++) begin
      d = $urandom();
      wr(12'hD10, d);
      chk("R8 sleep outs", {29'd0, sev_on_pend_o, sleep_deep_o, sleep_on_exit_o},
          {29'd0, d[4], d[2], d[1]});
      rd(12'hD10, r);
      chk("R8 sleep readback", r, d & 32'h0000_0016);
    end
    sl = {sev_on_pend_o, sleep_deep_o, sleep_on_exit_o};

    // R7 readback of keyed word
    rd(12'hD0C, r); chk("R7 rstc readback", r, 32'hFA05_0000);

    // R5 R6 unkeyed has no effect
    core_halted_i = 1'b1;
    wr(12'hD0C, 32'h05FB_0006);
    chk("R5 bad key rst_req", rst_req_o, 1'b0);
    chk("R6 bad key clr_active", clr_active_o, 1'b0);
    core_halted_i = 1'b0;
    wr(12'hD0C, 32'h05FA_0002);
    chk("R6 not halted no strobe", clr_active_o, 1'b0);
    core_halted_i = 1'b1;
    wr(12'hD0C, 32'h05FA_0002);
    chk("R6 halted strobe", clr_active_o, 1'b1);
    @(negedge clk);
    chk("R6 strobe one cycle", clr_active_o, 1'b0);

    // R6 random keyed/unkeyed, no reset bit
    for (int i = 0; i < 40; i++) begin
      logic key_ok, h;
      key_ok = 1'($urandom());
      h = 1'($urandom());
      d = $urandom() & ~32'h4;
      if (key_ok) d[31:16] = 16'h05FA;
      else if (d[31:16] == 16'h05FA) d[16] = ~d[16];
      core_halted_i = h;
      wr(12'hD0C, d);
      chk("R6 random clr_active", clr_active_o, key_ok & h & d[1]);
      chk("R5 no req without bit2", rst_req_o, 1'b0);
    end
    core_halted_i = 1'b0;

    // R10 unmapped offsets
    rd(12'hD00, r); chk("R10 unmapped read", r, '0);
    wr(12'hD14, 32'hFFFF_FFFF);
    chk("R10 unmapped write vtab", vtab_base_o, v);
    chk("R10 unmapped write sleep", {29'd0, sev_on_pend_o, sleep_deep_o, sleep_on_exit_o},
        {29'd0, sl});
    chk("R10 unmapped write strobes", outs() & 32'hFFFF_FFF8, '0);

    // R5 keyed reset request, sticky until reset
    wr(12'hD0C, 32'h05FA_0004);
    chk("R5 rst_req set", rst_req_o, 1'b1);
    wr(12'hD0C, 32'h1234_0000);
    repeat (4) @(negedge clk);
    chk("R5 rst_req held", rst_req_o, 1'b1);
    rst_ni = 1'b0;
    #1 chk("R5 rst_req cleared by reset", rst_req_o, 1'b0);
    chk("R9 vtab cleared by reset", vtab_base_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R5 rst_req stays low", rst_req_o, 1'b0);

    summary();
    $finish;
  end
endmodule